// File: doc/BRIEF.md
# Packet Command Task-File Device

This block is the device end of a packet-command storage interface, seen by a host through a small set of byte-wide task-file registers and one 16-bit data register. The host opens a packet command, writes a 12-byte command block as six 16-bit words, and then follows the device's status, interrupt-reason and byte-count values through a programmed-I/O data-in phase to completion. The block also accepts a device-reset command and a set-features command, and it shows failures either as a 4-bit sense key or as an abort code.

No real command decoding or media model sits behind the registers. A test side port loads the response: its byte length, its 16-bit words and an optional sense key. A global activation register gates the whole register window. While the window is disabled, every register reads as all ones.

Top module: `atapi_tf`

## Requirements
- R1: After reset, status and alternate status read 0x50, error reads 0x00, count reads 0x03, data reads 0xFFFF and the interrupt line is low.
- R2: Command 0xA0 written to index 8 enters the command-block phase: status 0x58, count 0x01, byte count low/high 0x08/0x00, interrupt line low.
- R3: After the sixth data-word write in that phase, status reads 0xD0 for BUSY_CYCLES clocks, and then the interrupt line rises.
- R4: With a non-zero length and no sense key, the data-in phase shows status 0x58, count 0x02 and the byte length in byte count low/high (index 5/6). Data reads return the response words in order from word 0.
- R5: The read of the last response word (word (length-1)/2) completes the command. The interrupt line rises, status reads 0x50, count reads 0x03, and data then reads 0xFFFF.
- R6: A response length of zero skips the data-in phase and completes directly, with status 0x50, count 0x03 and the interrupt line raised.
- R7: A non-zero sense key fails the command: status 0x51, count 0x03, error register = sense key in bits 7:4, interrupt line raised.
- R8: Command 0x08 leaves status 0x00, error 0x01, count 0x01, byte count 0x14/0xEB, data 0xFFFF, and does not raise the interrupt line.
- R9: Command 0xEF with feature 0x03 gives status 0x50 and error 0x00, keeps the count value written by the host, and does not raise the interrupt line. Any other feature, or any other command code, aborts: status 0x51, error 0x04, interrupt line raised.
- R10: Alternate status (index 0) always mirrors status and leaves the interrupt line unchanged. A status read (index 8) clears a pending interrupt.
- R11: While busy (status bit 7 set), host writes to task-file registers and to the command register have no effect.
- R12: Writing 0x000042FE to the activation register (index 15) disables the window, and every 32-bit read of indices 0 to 14 then returns 0xFFFFFFFF. Writes are also ignored. Writing any other value re-enables the window with its state unchanged.
- R13: Register indices: 0 alternate status, 1 data, 2 error on read / feature on write, 3 count, 4 sector, 5 byte count low, 6 byte count high, 7 device select, 8 status on read / command on write, 15 activation. Sector and device select read back the value last written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostAddr | input | 4 | Register index |
| hostWr | input | 1 | Host write strobe |
| hostRd | input | 1 | Host read strobe (side effects at the clock edge) |
| hostWdata | input | 32 | Host write data |
| hostRdata | output | 32 | Read data for hostAddr, combinational |
| intrq | output | 1 | Device interrupt request |
| tstWordWe | input | 1 | Test port: response word write |
| tstWordIdx | input | $clog2(RSP_WORDS) | Test port: response word index |
| tstWord | input | 16 | Test port: response word value |
| tstCfgWe | input | 1 | Test port: load length and sense key |
| tstLen | input | LEN_W | Test port: response length in bytes |
| tstSense | input | 4 | Test port: sense key, zero for success |

## Verification
A wrong phase or a stale pointer shows up on the first register read after the event. Status, count and byte count are fixed values for each phase, so a device stuck busy, or a device that skipped the command-block phase, is caught one cycle after the faulty edge. A data pointer that advances wrongly returns a word out of order, or ends the transfer early, and the next data read or status read shows this. Interrupt faults appear on the interrupt pin in the cycle after the edge that should have set it or cleared it. The disabled-window check reads all-ones on 32 bits, so a gate that leaks even one register is visible.

// File: rtl/atapi_tf_pkg.sv
package atapi_tf_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_PKT, PH_BUSY, PH_DIN} phase_e;

  typedef struct packed {
    logic regWr;
    logic enterPkt;
    logic devReset;
    logic featOk;
    logic abortCmd;
    logic goBusy;
    logic enterDin;
    logic complete;
    logic senseErr;
  } tfStrobe_t;

  localparam logic [3:0] IDX_ALT    = 4'd0;
  localparam logic [3:0] IDX_DATA   = 4'd1;
  localparam logic [3:0] IDX_FEAT   = 4'd2;
  localparam logic [3:0] IDX_COUNT  = 4'd3;
  localparam logic [3:0] IDX_SECTOR = 4'd4;
  localparam logic [3:0] IDX_BCLO   = 4'd5;
  localparam logic [3:0] IDX_BCHI   = 4'd6;
  localparam logic [3:0] IDX_DEV    = 4'd7;
  localparam logic [3:0] IDX_CMD    = 4'd8;
  localparam logic [3:0] IDX_ACT    = 4'd15;

  localparam logic [31:0] ACT_OFF = 32'h0000_42FE;
  localparam logic [7:0]  CMD_PKT = 8'hA0;
  localparam logic [7:0]  CMD_RST = 8'h08;
  localparam logic [7:0]  CMD_FEAT = 8'hEF;
  localparam logic [7:0]  FEAT_XFER = 8'h03;
endpackage

// File: rtl/atapi_tf_ctrl.sv
module atapi_tf_ctrl
  import atapi_tf_pkg::*;
#(
  parameter int BUSY_CYCLES = 4,
  parameter int RSP_WORDS   = 8,
  parameter int LEN_W       = 16,
  parameter int PTR_W       = $clog2(RSP_WORDS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [3:0]       hostAddr,
  input  logic             hostWr,
  input  logic             hostRd,
  input  logic [31:0]      hostWdata,
  input  logic [7:0]       featByte,
  input  logic [LEN_W-1:0] rspLen,
  input  logic [3:0]       rspSense,
  output tfStrobe_t        st,
  output logic             intrq,
  output logic             enabled,
  output logic             busy,
  output logic             pktPhase,
  output logic             inDin,
  output logic [PTR_W-1:0] ptr
);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

  phase_e           phaseQ;
  logic [2:0]       pktCntQ;
  logic [CNT_W-1:0] busyCntQ;
  logic [PTR_W-1:0] ptrQ;
  logic             enabledQ;
  logic             intrqQ;

  logic             taskWr, cmdWr, pktWord, busyDone, dinRd, statRd, lastWord, actWr;
  logic [LEN_W-1:0] lastIdx;

  always_comb begin
    actWr    = hostWr && (hostAddr == IDX_ACT);
    taskWr   = enabledQ && hostWr && (phaseQ != PH_BUSY) && (hostAddr != IDX_ACT);
    cmdWr    = taskWr && (hostAddr == IDX_CMD);
    pktWord  = taskWr && (hostAddr == IDX_DATA) && (phaseQ == PH_PKT);
    busyDone = (phaseQ == PH_BUSY) && (busyCntQ == '0);
    dinRd    = enabledQ && hostRd && (hostAddr == IDX_DATA) && (phaseQ == PH_DIN);
    statRd   = enabledQ && hostRd && (hostAddr == IDX_CMD);
    lastIdx  = (rspLen - 1'b1) >> 1;
    lastWord = (LEN_W'(ptrQ) == lastIdx);

    st = '0;
    st.regWr = taskWr && (hostAddr >= IDX_FEAT) && (hostAddr <= IDX_DEV);
    if (cmdWr) begin
      case (hostWdata[7:0])
        CMD_PKT:  st.enterPkt = 1'b1;
        CMD_RST:  st.devReset = 1'b1;
        CMD_FEAT: begin
          if (featByte == FEAT_XFER) st.featOk = 1'b1;
          else                       st.abortCmd = 1'b1;
        end
        default:  st.abortCmd = 1'b1;
      endcase
    end
    st.goBusy = pktWord && (pktCntQ == 3'd5);
    if (busyDone) begin
      if (rspSense != 4'd0)    st.senseErr  = 1'b1;
      else if (rspLen == '0)   st.complete  = 1'b1;
      else                     st.enterDin  = 1'b1;
    end
    if (dinRd && lastWord) st.complete = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ   <= PH_IDLE;
      pktCntQ  <= '0;
      busyCntQ <= '0;
      ptrQ     <= '0;
      enabledQ <= 1'b1;
      intrqQ   <= 1'b0;
    end else begin
      if (actWr) enabledQ <= (hostWdata != ACT_OFF);

      if (st.abortCmd || st.senseErr || st.complete || st.enterDin) intrqQ <= 1'b1;
      else if (st.enterPkt || statRd)                               intrqQ <= 1'b0;

      if (st.enterPkt) begin
        phaseQ  <= PH_PKT;
        pktCntQ <= '0;
      end else if (st.devReset || st.featOk || st.abortCmd) begin
        phaseQ <= PH_IDLE;
      end else if (st.goBusy) begin
        phaseQ   <= PH_BUSY;
        busyCntQ <= CNT_W'(BUSY_CYCLES - 1);
      end else if (pktWord) begin
        pktCntQ <= pktCntQ + 3'd1;
      end else if (busyDone) begin
        phaseQ <= st.enterDin ? PH_DIN : PH_IDLE;
        ptrQ   <= '0;
      end else if (phaseQ == PH_BUSY) begin
        busyCntQ <= busyCntQ - 1'b1;
      end else if (dinRd) begin
        ptrQ <= ptrQ + 1'b1;
        if (lastWord) phaseQ <= PH_IDLE;
      end
    end
  end

  assign intrq    = intrqQ;
  assign enabled  = enabledQ;
  assign busy     = (phaseQ == PH_BUSY);
  assign pktPhase = (phaseQ == PH_PKT);
  assign inDin    = (phaseQ == PH_DIN);
  assign ptr      = ptrQ;
endmodule

// File: rtl/atapi_tf_dpath.sv
module atapi_tf_dpath
  import atapi_tf_pkg::*;
#(
  parameter int RSP_WORDS = 8,
  parameter int LEN_W     = 16,
  parameter int PTR_W     = $clog2(RSP_WORDS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  tfStrobe_t        st,
  input  logic [3:0]       hostAddr,
  input  logic [7:0]       wrByte,
  input  logic             enabled,
  input  logic             inDin,
  input  logic [PTR_W-1:0] ptr,
  input  logic             tstWordWe,
  input  logic [PTR_W-1:0] tstWordIdx,
  input  logic [15:0]      tstWord,
  input  logic             tstCfgWe,
  input  logic [LEN_W-1:0] tstLen,
  input  logic [3:0]       tstSense,
  output logic [31:0]      rdData,
  output logic [7:0]       featByte,
  output logic [LEN_W-1:0] rspLen,
  output logic [3:0]       rspSense,
  output logic [7:0]       statusByte,
  output logic [7:0]       errByte
);
  logic [7:0]       statusQ, errQ, countQ, sectorQ, bcLoQ, bcHiQ, devQ, featQ;
  logic [LEN_W-1:0] rspLenQ;
  logic [3:0]       rspSenseQ;
  logic [15:0]      bufQ [RSP_WORDS];
  logic [15:0]      lenBytes;

  assign lenBytes = 16'(rspLenQ);

  for (genvar w = 0; w < RSP_WORDS; w++) begin : g_buf
    always_ff @(posedge clk) begin
      if (tstWordWe && (tstWordIdx == PTR_W'(w))) bufQ[w] <= tstWord;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ   <= 8'h50;
      errQ      <= 8'h00;
      countQ    <= 8'h03;
      sectorQ   <= 8'h00;
      bcLoQ     <= 8'h00;
      bcHiQ     <= 8'h00;
      devQ      <= 8'h00;
      featQ     <= 8'h00;
      rspLenQ   <= '0;
      rspSenseQ <= '0;
    end else begin
      if (tstCfgWe) begin
        rspLenQ   <= tstLen;
        rspSenseQ <= tstSense;
      end
      if (st.regWr) begin
        case (hostAddr)
          IDX_FEAT:   featQ   <= wrByte;
          IDX_COUNT:  countQ  <= wrByte;
          IDX_SECTOR: sectorQ <= wrByte;
          IDX_BCLO:   bcLoQ   <= wrByte;
          IDX_BCHI:   bcHiQ   <= wrByte;
          IDX_DEV:    devQ    <= wrByte;
          default: ;
        endcase
      end
      if (st.enterPkt) begin
        statusQ <= 8'h58; countQ <= 8'h01; bcLoQ <= 8'h08; bcHiQ <= 8'h00; errQ <= 8'h00;
      end
      if (st.devReset) begin
        statusQ <= 8'h00; errQ <= 8'h01; countQ <= 8'h01; bcLoQ <= 8'h14; bcHiQ <= 8'hEB;
      end
      if (st.featOk) begin
        statusQ <= 8'h50; errQ <= 8'h00;
      end
      if (st.abortCmd) begin
        statusQ <= 8'h51; errQ <= 8'h04;
      end
      if (st.goBusy) statusQ <= 8'hD0;
      if (st.enterDin) begin
        statusQ <= 8'h58; countQ <= 8'h02; errQ <= 8'h00;
        bcLoQ <= lenBytes[7:0]; bcHiQ <= lenBytes[15:8];
      end
      if (st.complete) begin
        statusQ <= 8'h50; countQ <= 8'h03; errQ <= 8'h00;
      end
      if (st.senseErr) begin
        statusQ <= 8'h51; countQ <= 8'h03; errQ <= {rspSenseQ, 4'h0};
      end
    end
  end

  always_comb begin
    if (!enabled && hostAddr != IDX_ACT) begin
      rdData = '1;
    end else begin
      case (hostAddr)
        IDX_ALT, IDX_CMD: rdData = 32'(statusQ);
        IDX_DATA:   rdData = inDin ? 32'(bufQ[ptr]) : 32'h0000_FFFF;
        IDX_FEAT:   rdData = 32'(errQ);
        IDX_COUNT:  rdData = 32'(countQ);
        IDX_SECTOR: rdData = 32'(sectorQ);
        IDX_BCLO:   rdData = 32'(bcLoQ);
        IDX_BCHI:   rdData = 32'(bcHiQ);
        IDX_DEV:    rdData = 32'(devQ);
        default:    rdData = 32'h0;
      endcase
    end
  end

  assign featByte   = featQ;
  assign rspLen     = rspLenQ;
  assign rspSense   = rspSenseQ;
  assign statusByte = statusQ;
  assign errByte    = errQ;
endmodule

// File: rtl/atapi_tf.sv
module atapi_tf
  import atapi_tf_pkg::*;
#(
  parameter int BUSY_CYCLES = 4,
  parameter int RSP_WORDS   = 8,
  parameter int LEN_W       = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [3:0]                   hostAddr,
  input  logic                         hostWr,
  input  logic                         hostRd,
  input  logic [31:0]                  hostWdata,
  output logic [31:0]                  hostRdata,
  output logic                         intrq,
  input  logic                         tstWordWe,
  input  logic [$clog2(RSP_WORDS)-1:0] tstWordIdx,
  input  logic [15:0]                  tstWord,
  input  logic                         tstCfgWe,
  input  logic [LEN_W-1:0]             tstLen,
  input  logic [3:0]                   tstSense
);
  localparam int PTR_W = $clog2(RSP_WORDS);

  tfStrobe_t        st;
  logic             isEnabled, busy, pktPhase, inDin;
  logic [PTR_W-1:0] ptr;
  logic [7:0]       featByte, statusByte, errByte;
  logic [LEN_W-1:0] rspLen;
  logic [3:0]       rspSense;

  atapi_tf_ctrl #(.BUSY_CYCLES(BUSY_CYCLES), .RSP_WORDS(RSP_WORDS), .LEN_W(LEN_W), .PTR_W(PTR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWr(hostWr), .hostRd(hostRd),
    .hostWdata(hostWdata), .featByte(featByte), .rspLen(rspLen), .rspSense(rspSense),
    .st(st), .intrq(intrq), .enabled(isEnabled), .busy(busy), .pktPhase(pktPhase),
    .inDin(inDin), .ptr(ptr)
  );

  atapi_tf_dpath #(.RSP_WORDS(RSP_WORDS), .LEN_W(LEN_W), .PTR_W(PTR_W)) u_dpath (
    .clk(clk), .rstN(rstN), .st(st), .hostAddr(hostAddr), .wrByte(hostWdata[7:0]),
    .enabled(isEnabled), .inDin(inDin), .ptr(ptr),
    .tstWordWe(tstWordWe), .tstWordIdx(tstWordIdx), .tstWord(tstWord),
    .tstCfgWe(tstCfgWe), .tstLen(tstLen), .tstSense(tstSense),
    .rdData(hostRdata), .featByte(featByte), .rspLen(rspLen), .rspSense(rspSense),
    .statusByte(statusByte), .errByte(errByte)
  );
endmodule

// File: rtl/atapi_tf_chk.sv
module atapi_tf_chk (
  input logic        clk,
  input logic        rstN,
  input logic [3:0]  hostAddr,
  input logic        hostWr,
  input logic        hostRd,
  input logic [31:0] hostWdata,
  input logic        intrq,
  input logic        isEnabled,
  input logic        busy,
  input logic        pktPhase,
  input logic [7:0]  statusByte,
  input logic [7:0]  errByte
);
  assert_busy_status_R3: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> statusByte == 8'hD0);

  assert_pkt_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    pktPhase |-> (!intrq && statusByte == 8'h58));

  assert_reset_no_irq_R8: assert property (@(posedge clk) disable iff (!rstN)
    (isEnabled && hostWr && hostAddr == 4'd8 && hostWdata[7:0] == 8'h08 && !busy && !intrq) |=> !intrq);

  assert_status_read_clears_R10: assert property (@(posedge clk) disable iff (!rstN)
    (isEnabled && hostRd && !hostWr && hostAddr == 4'd8 && !busy) |=> !intrq);

  assert_alt_read_keeps_R10: assert property (@(posedge clk) disable iff (!rstN)
    (isEnabled && hostRd && !hostWr && hostAddr == 4'd0 && intrq) |=> intrq);

  assert_err_has_code_R7: assert property (@(posedge clk) disable iff (!rstN)
    statusByte[0] |-> errByte != 8'h00);
endmodule

bind atapi_tf atapi_tf_chk u_chk (
  .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWr(hostWr), .hostRd(hostRd),
  .hostWdata(hostWdata), .intrq(intrq), .isEnabled(isEnabled), .busy(busy),
  .pktPhase(pktPhase), .statusByte(statusByte), .errByte(errByte)
);

// File: tb/atapi_tf_tb.sv
`timescale 1ns/1ps
module atapi_tf_tb;
  localparam int BUSY = 4;
  localparam int NV   = 58;
  // entry = {op[31:28], idx[27:24], value[23:8], requirement[7:0]}
  // op 0 write, 1 read and compare, 2 wait busy interval, 3 compare intrq
  localparam logic [31:0] VEC [NV] = '{
    32'h0800A002, 32'h10005802, 32'h13000102, 32'h15000802, 32'h16000002, 32'h30000002, // R2
    32'h01000003, 32'h01000003, 32'h01000003, 32'h01000003, 32'h01000003, 32'h01000003, // R3
    32'h1000D003, 32'h30000003, 32'h20000003, 32'h30000103,                             // R3
    32'h10005804, 32'h3000010A, 32'h13000204, 32'h15000604, 32'h16000004,               // R4 R10
    32'h1800580A, 32'h3000000A,                                                         // R10
    32'h11111104, 32'h11222204, 32'h11333305,                                           // R4 R5
    32'h30000105, 32'h10005005, 32'h13000305, 32'h11FFFF05, 32'h1800500A, 32'h3000000A, // R5 R10
    32'h02000309, 32'h03000B09, 32'h0800EF09, 32'h10005009, 32'h13000B09, 32'h12000009,
    32'h30000009,                                                                       // R9
    32'h02005509, 32'h0800EF09, 32'h10005109, 32'h12000409, 32'h30000109,
    32'h1800510A, 32'h3000000A,                                                         // R9 R10
    32'h08000808, 32'h10000008, 32'h12000108, 32'h13000108, 32'h15001408, 32'h1600EB08,
    32'h11FFFF08, 32'h30000008,                                                         // R8
    32'h0700A50D, 32'h1700A50D, 32'h04005A0D, 32'h14005A0D                              // R13
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  hostAddr = '0;
  logic        hostWr = 1'b0, hostRd = 1'b0;
  logic [31:0] hostWdata = '0;
  logic [31:0] hostRdata;
  logic        intrq;
  logic        tstWordWe = 1'b0;
  logic [2:0]  tstWordIdx = '0;
  logic [15:0] tstWord = '0;
  logic        tstCfgWe = 1'b0;
  logic [15:0] tstLen = '0;
  logic [3:0]  tstSense = '0;
  int          nChk = 0, nBad = 0;

  always #5 clk = ~clk;

  atapi_tf #(.BUSY_CYCLES(BUSY), .RSP_WORDS(8), .LEN_W(16)) u_dut (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWr(hostWr), .hostRd(hostRd),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .intrq(intrq),
    .tstWordWe(tstWordWe), .tstWordIdx(tstWordIdx), .tstWord(tstWord),
    .tstCfgWe(tstCfgWe), .tstLen(tstLen), .tstSense(tstSense)
  );

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    hostAddr = a; hostWdata = d; hostWr = 1'b1;
    @(negedge clk); hostWr = 1'b0;
  endtask

  task automatic rdChk(input logic [3:0] a, input logic [31:0] exp, input logic full, input string req);
    hostAddr = a; hostRd = 1'b1;
    #2;
    nChk++;
    if ((full ? hostRdata : {16'h0, hostRdata[15:0]}) != exp) begin
      nBad++;
      $display("FAIL %s idx %0d actual %h expected %h", req, a, hostRdata, exp);
    end
    @(negedge clk); hostRd = 1'b0;
  endtask

  task automatic irqChk(input logic exp, input string req);
    #2;
    nChk++;
    if (intrq !== exp) begin
      nBad++;
      $display("FAIL %s intrq actual %0b expected %0b", req, intrq, exp);
    end
    @(negedge clk);
  endtask

  task automatic loadWord(input int i, input logic [15:0] v);
    tstWordIdx = 3'(i); tstWord = v; tstWordWe = 1'b1;
    @(negedge clk); tstWordWe = 1'b0;
  endtask

  task automatic loadCfg(input logic [15:0] len, input logic [3:0] sense);
    tstLen = len; tstSense = sense; tstCfgWe = 1'b1;
    @(negedge clk); tstCfgWe = 1'b0;
  endtask

  task automatic sendPacket();
    wr(4'd8, 32'hA0);
    for (int k = 0; k < 6; k++) wr(4'd1, 32'(k));
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  endtask

  initial begin
    #2_000_000;
    nChk++; nBad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    loadWord(0, 16'h1111); loadWord(1, 16'h2222); loadWord(2, 16'h3333);
    loadCfg(16'd6, 4'd0);

    for (int v = 0; v < NV; v++) begin
      logic [3:0]  op, idx;
      logic [15:0] val;
      string       tag;
      op = VEC[v][31:28]; idx = VEC[v][27:24]; val = VEC[v][23:8];
      tag = $sformatf("R%0d", VEC[v][7:0]);
      case (op)
        4'd0: wr(idx, 32'(val));
        4'd1: rdChk(idx, 32'(val), 1'b0, tag);
        4'd2: repeat (BUSY) @(negedge clk);
        default: irqChk(val[0], tag);
      endcase
    end

    // R1: reset state
    rstN = 1'b0; @(negedge clk); rstN = 1'b1; @(negedge clk);
    irqChk(1'b0, "R1");
    rdChk(4'd0, 32'h50, 1'b0, "R1");
    rdChk(4'd8, 32'h50, 1'b0, "R1");
    rdChk(4'd2, 32'h00, 1'b0, "R1");
    rdChk(4'd3, 32'h03, 1'b0, "R1");
    rdChk(4'd1, 32'hFFFF, 1'b0, "R1");

    // R7: failure with sense key 6
    loadCfg(16'd4, 4'd6);
    sendPacket();
    repeat (BUSY) @(negedge clk);
    irqChk(1'b1, "R7");
    rdChk(4'd0, 32'h51, 1'b0, "R7");
    rdChk(4'd3, 32'h03, 1'b0, "R7");
    rdChk(4'd2, 32'h60, 1'b0, "R7");
    rdChk(4'd8, 32'h51, 1'b0, "R7");

    // R6: zero length completes without data phase
    loadCfg(16'd0, 4'd0);
    sendPacket();
    repeat (BUSY) @(negedge clk);
    irqChk(1'b1, "R6");
    rdChk(4'd0, 32'h50, 1'b0, "R6");
    rdChk(4'd3, 32'h03, 1'b0, "R6");
    rdChk(4'd1, 32'hFFFF, 1'b0, "R6");
    rdChk(4'd8, 32'h50, 1'b0, "R6");

    // R11: writes during busy are dropped
    loadWord(0, 16'hBEEF);
    loadCfg(16'd2, 4'd0);
    wr(4'd7, 32'h11);
    sendPacket();
    wr(4'd7, 32'h22);
    wr(4'd8, 32'h08);
    repeat (BUSY) @(negedge clk);
    rdChk(4'd7, 32'h11, 1'b0, "R11");
    rdChk(4'd0, 32'h58, 1'b0, "R11");
    rdChk(4'd3, 32'h02, 1'b0, "R11");
    rdChk(4'd1, 32'hBEEF, 1'b0, "R4");
    rdChk(4'd0, 32'h50, 1'b0, "R5");

    // R12: disabled window reads all ones, writes ignored
    wr(4'd15, 32'h0000_42FE);
    rdChk(4'd0, 32'hFFFF_FFFF, 1'b1, "R12");
    rdChk(4'd3, 32'hFFFF_FFFF, 1'b1, "R12");
    rdChk(4'd8, 32'hFFFF_FFFF, 1'b1, "R12");
    rdChk(4'd14, 32'hFFFF_FFFF, 1'b1, "R12");
    wr(4'd7, 32'h99);
    wr(4'd15, 32'h1);
    rdChk(4'd7, 32'h11, 1'b0, "R12");
    rdChk(4'd0, 32'h50, 1'b0, "R12");

    summary();
  end
endmodule